// File: doc/BRIEF.md
# Priority Interrupt Request Core

This block collects interrupt requests from eight lines, arbitrates among them with a fixed priority, and signals a processor through a single interrupt output. The processor answers with two pulses on an active-low acknowledge strobe. The first pulse moves the winning request into service. The second pulse makes the block present a vector byte, formed from a programmable base plus the line number.

Each line in service blocks itself and every line of lower priority until an end-of-interrupt (EOI) clears its in-service bit. The EOI can happen automatically at the second pulse. It can also be issued explicitly, either naming a level or, in the non-specific form, taking the highest-priority bit in service.

A mask register, loaded through a write strobe, removes lines from arbitration. The request and in-service registers are visible at all times.

The acknowledge handshake is a three-state machine:
- **IDLE**: a falling edge of the strobe takes the transition *select*, which moves to **CHOSEN**.
- **CHOSEN**: the next falling edge takes the transition *present*, which moves to **DRIVE**.
- **DRIVE**: a sampled high strobe takes the transition *release*, which returns to **IDLE**.

Top module: `prio_irq_core`

## Requirements
- R1: In edge mode (`level_mode`=0), a request bit is set in the cycle after its line is sampled low and then high on consecutive clocks. It stays set, even while the line remains high, until it is granted.
- R2: In level mode (`level_mode`=1), a request bit follows its line one clock later, and it is forced to 0 in the cycle it is granted.
- R3: `mask_wr` loads `mask_data` into the mask register; bit i=1 masks line i. A masked request still shows in `irr_rd` but is excluded from arbitration and from `irq_out`.
- R4: `irq_out` is 1 exactly when some unmasked request bit i exists such that no in-service bit j with j<=i is set.
- R5: An acknowledge pulse starts when `ack_n` is sampled high and then low on consecutive clocks. At the first pulse, the eligible request with the lowest index (line 0 highest) is granted: its in-service bit is set and its request bit cleared at the same edge.
- R6: At the second pulse, `vec_out` becomes `vec_base` plus the served line number, modulo 256. `vec_valid` is 1 from that edge until `ack_n` is next sampled high.
- R7: With `auto_eoi`=1, the in-service bit of the served line is cleared at the second pulse.
- R8: A specific EOI (`eoi_valid`=1, `eoi_specific`=1) clears in-service bit `eoi_level`.
- R9: A non-specific EOI (`eoi_valid`=1, `eoi_specific`=0) clears the lowest-index in-service bit that is set.
- R10: If no request is eligible at the first pulse, line 7 is served with vector `vec_base`+7, and the in-service and request registers are left unchanged.
- R11: Reset clears the request and in-service registers, sets all mask bits, and deasserts `irq_out` and `vec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_line | input | 8 | Interrupt request lines |
| level_mode | input | 1 | 1 = level-sensitive requests, 0 = edge |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_data | input | 8 | New mask value |
| vec_base | input | 8 | Vector base added to the line number |
| auto_eoi | input | 1 | Clear in-service bit at second acknowledge |
| eoi_valid | input | 1 | EOI command strobe |
| eoi_specific | input | 1 | 1 = specific EOI, 0 = non-specific |
| eoi_level | input | 3 | Line cleared by a specific EOI |
| ack_n | input | 1 | Active-low acknowledge strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector byte |
| vec_valid | output | 1 | Vector byte is being driven |
| irr_rd | output | 8 | Request register read-back |
| isr_rd | output | 8 | In-service register read-back |

## Verification
Arbitration is tried in several situations:
- Two simultaneous requests, which separates lowest-index selection from any other order.
- A higher-priority request arriving while a lower one is in service, which separates nesting from blanket blocking.
- A request pending under its own in-service level, which shows equal-priority blocking.
- A masked-only request, which must both stay visible and draw a spurious vector.

EOI is exercised in all three of its forms, each of which clears a different bit when several are in service. Level and edge latching are contrasted by holding and dropping lines across grants. A vector base near 255 exposes the wrap of the addition.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHOSEN = 2'd1,
        ST_DRIVE  = 2'd2
    } ack_state_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level_mode,
    input  logic [NLINES-1:0] req_line,
    input  logic [NLINES-1:0] grant_clr,
    output logic [NLINES-1:0] irr
);
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic prev_q;
        logic req_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                req_q  <= 1'b0;
            end else begin
                prev_q <= req_line[g];
                if (level_mode)
                    req_q <= req_line[g] & ~grant_clr[g];
                else
                    req_q <= (req_q & ~grant_clr[g]) | (req_line[g] & ~prev_q);
            end
        end
        assign irr[g] = req_q;
    end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
    parameter int NLINES = 8,
    localparam int LW = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] pending,
    input  logic [NLINES-1:0] isr,
    output logic              any_elig,
    output logic [LW-1:0]     winner,
    output logic              isr_any,
    output logic [LW-1:0]     isr_top
);
    logic [NLINES-1:0] elig;
    logic              seen;

    always_comb begin
        seen = 1'b0;
        for (int i = 0; i < NLINES; i++) begin
            seen    = seen | isr[i];
            elig[i] = pending[i] & ~seen;
        end
        any_elig = |elig;
        isr_any  = |isr;
        winner   = '0;
        isr_top  = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (elig[i]) winner  = LW'(i);
            if (isr[i])  isr_top = LW'(i);
        end
    end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_core_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    output logic first_pulse,
    output logic second_pulse,
    output logic driving
);
    ack_state_e state_q, state_d;
    logic       ack_prev_q;
    logic       ack_fall;

    assign ack_fall = ack_prev_q & ~ack_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ack_prev_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            ack_prev_q <= ack_n;
        end
    end

    always_comb begin
        state_d      = state_q;
        first_pulse  = 1'b0;
        second_pulse = 1'b0;
        driving      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_fall) begin
                    first_pulse = 1'b1;
                    state_d     = ST_CHOSEN;
                end
            end
            ST_CHOSEN: begin
                if (ack_fall) begin
                    second_pulse = 1'b1;
                    state_d      = ST_DRIVE;
                end
            end
            ST_DRIVE: begin
                driving = 1'b1;
                if (ack_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/prio_irq_core.sv
module prio_irq_core #(
    parameter int NLINES = 8,
    parameter int VW     = 8,
    localparam int LW    = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] req_line,
    input  logic              level_mode,
    input  logic              mask_wr,
    input  logic [NLINES-1:0] mask_data,
    input  logic [VW-1:0]     vec_base,
    input  logic              auto_eoi,
    input  logic              eoi_valid,
    input  logic              eoi_specific,
    input  logic [LW-1:0]     eoi_level,
    input  logic              ack_n,
    output logic              irq_out,
    output logic [VW-1:0]     vec_out,
    output logic              vec_valid,
    output logic [NLINES-1:0] irr_rd,
    output logic [NLINES-1:0] isr_rd
);
    localparam logic [LW-1:0]     SPUR_LINE = LW'(NLINES - 1);
    localparam logic [NLINES-1:0] ONE       = NLINES'(1);

    logic [NLINES-1:0] irr, isr_q, mask_q, grant_clr;
    logic [NLINES-1:0] auto_clr, eoi_clr;
    logic              any_elig, isr_any, first_pulse, second_pulse, driving;
    logic [LW-1:0]     winner, isr_top, line_q;
    logic              spur_q;
    logic [VW-1:0]     vec_q;

    irq_req_latch #(.NLINES(NLINES)) u_latch (
        .clk(clk), .rst_n(rst_n), .level_mode(level_mode),
        .req_line(req_line), .grant_clr(grant_clr), .irr(irr)
    );

    irq_resolver #(.NLINES(NLINES)) u_resolve (
        .pending(irr & ~mask_q), .isr(isr_q), .any_elig(any_elig),
        .winner(winner), .isr_any(isr_any), .isr_top(isr_top)
    );

    irq_ack_ctrl u_ack (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n),
        .first_pulse(first_pulse), .second_pulse(second_pulse), .driving(driving)
    );

    assign grant_clr = (first_pulse && any_elig) ? (ONE << winner) : '0;
    assign auto_clr  = (second_pulse && auto_eoi && !spur_q) ? (ONE << line_q) : '0;

    always_comb begin
        eoi_clr = '0;
        if (eoi_valid) begin
            if (eoi_specific)  eoi_clr = ONE << eoi_level;
            else if (isr_any)  eoi_clr = ONE << isr_top;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            isr_q  <= '0;
            line_q <= '0;
            spur_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            if (mask_wr) mask_q <= mask_data;
            isr_q <= (isr_q | grant_clr) & ~auto_clr & ~eoi_clr;
            if (first_pulse) begin
                line_q <= any_elig ? winner : SPUR_LINE;
                spur_q <= ~any_elig;
            end
            if (second_pulse) vec_q <= vec_base + VW'(line_q);
        end
    end

    assign irq_out   = any_elig;
    assign vec_out   = vec_q;
    assign vec_valid = driving;
    assign irr_rd    = irr;
    assign isr_rd    = isr_q;

    assert_grant_sets_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (first_pulse && any_elig && !eoi_valid) |=> isr_q[$past(winner)]);

    assert_spurious_keeps_isr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (first_pulse && !any_elig && !eoi_valid) |=> $stable(isr_q));

    assert_vector_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        second_pulse |=> (vec_valid && vec_out == $past(vec_base) + VW'($past(line_q))));

    assert_top_blocks_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        isr_q[0] |-> !irq_out);

    assert_specific_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_specific && !first_pulse) |=> !isr_q[$past(eoi_level)]);

    assert_auto_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (second_pulse && auto_eoi && !spur_q && !first_pulse) |=> !isr_q[$past(line_q)]);
endmodule

// File: tb/prio_irq_core_test.sv
`timescale 1ns/1ps
module prio_irq_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_line = '0;
    logic       level_mode = 1'b0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_data = '0;
    logic [7:0] vec_base = 8'h20;
    logic       auto_eoi = 1'b0;
    logic       eoi_valid = 1'b0;
    logic       eoi_specific = 1'b0;
    logic [2:0] eoi_level = '0;
    logic       ack_n = 1'b1;
    logic       irq_out, vec_valid;
    logic [7:0] vec_out, irr_rd, isr_rd;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    prio_irq_core uut (
        .clk(clk), .rst_n(rst_n), .req_line(req_line), .level_mode(level_mode),
        .mask_wr(mask_wr), .mask_data(mask_data), .vec_base(vec_base),
        .auto_eoi(auto_eoi), .eoi_valid(eoi_valid), .eoi_specific(eoi_specific),
        .eoi_level(eoi_level), .ack_n(ack_n), .irq_out(irq_out), .vec_out(vec_out),
        .vec_valid(vec_valid), .irr_rd(irr_rd), .isr_rd(isr_rd)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    logic [7:0] m_irr, m_isr, m_mask, m_reqp, m_vec;
    logic       m_ackp, m_spur;
    int         m_st, m_line;

    function automatic int m_pick(logic [7:0] irr, logic [7:0] isr, logic [7:0] msk);
        for (int i = 0; i < 8; i++) begin
            if (isr[i]) return -1;
            if (irr[i] && !msk[i]) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_irr = '0; m_isr = '0; m_mask = '1; m_reqp = '0; m_vec = '0;
            m_ackp = 1'b1; m_spur = 1'b0; m_st = 0; m_line = 0;
        end else begin
            logic [7:0] g, aclr, eclr;
            logic       fall;
            int         w;
            g = '0; aclr = '0; eclr = '0;
            fall = m_ackp && !ack_n;
            if (m_st == 0 && fall) begin
                w = m_pick(m_irr, m_isr, m_mask);
                if (w >= 0) begin m_line = w; m_spur = 0; g[w] = 1'b1; end
                else begin m_line = 7; m_spur = 1; end
                m_st = 1;
            end else if (m_st == 1 && fall) begin
                m_vec = vec_base + 8'(m_line);
                if (auto_eoi && !m_spur) aclr[m_line] = 1'b1;
                m_st = 2;
            end else if (m_st == 2 && ack_n) begin
                m_st = 0;
            end
            if (eoi_valid) begin
                if (eoi_specific) eclr[eoi_level] = 1'b1;
                else for (int i = 7; i >= 0; i--) if (m_isr[i]) eclr = 8'(1) << i;
            end
            m_isr = (m_isr | g) & ~aclr & ~eclr;
            if (level_mode) m_irr = req_line & ~g;
            else            m_irr = (m_irr & ~g) | (req_line & ~m_reqp);
            m_reqp = req_line;
            if (mask_wr) m_mask = mask_data;
            m_ackp = ack_n;
        end
    end

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            cmp("R1,R2,R5 irr model", 32'(irr_rd), 32'(m_irr));
            cmp("R5,R7,R8,R9 isr model", 32'(isr_rd), 32'(m_isr));
            cmp("R4 irq model", 32'(irq_out), 32'(m_pick(m_irr, m_isr, m_mask) >= 0));
            cmp("R6 vec_valid model", 32'(vec_valid), 32'(m_st == 2));
            if (m_st == 2) cmp("R6 vec_out model", 32'(vec_out), 32'(m_vec));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_pair(output logic [7:0] v, output logic vv);
        ack_n = 1'b0; tick(2);
        ack_n = 1'b1; tick(2);
        ack_n = 1'b0; tick(2);
        v = vec_out; vv = vec_valid;
        ack_n = 1'b1; tick(2);
    endtask

    task automatic send_eoi(logic spec, logic [2:0] lvl);
        eoi_valid = 1'b1; eoi_specific = spec; eoi_level = lvl;
        tick(1);
        eoi_valid = 1'b0; tick(1);
    endtask

    task automatic load_mask(logic [7:0] m);
        mask_wr = 1'b1; mask_data = m; tick(1);
        mask_wr = 1'b0; tick(1);
    endtask

    initial begin
        logic [7:0] v;
        logic vv;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        cmp("R11 irr reset", 32'(irr_rd), 0);
        cmp("R11 isr reset", 32'(isr_rd), 0);
        cmp("R11 irq reset", 32'(irq_out), 0);
        cmp("R11 vec_valid reset", 32'(vec_valid), 0);
        req_line = 8'h01; tick(2);
        cmp("R11 mask all set, irq low", 32'(irq_out), 0);
        cmp("R3 masked request visible", 32'(irr_rd), 32'h01);
        load_mask(8'h00); tick(1);
        cmp("R3 unmasked raises irq", 32'(irq_out), 1);
        ack_pair(v, vv);
        cmp("R6 vec line0", 32'(v), 32'h20);
        send_eoi(1'b0, 3'd0);
        req_line = 8'h00; tick(2);

        // edge mode, two requests
        req_line = 8'h28; tick(2);
        cmp("R1 edge latch", 32'(irr_rd), 32'h28);
        cmp("R4 irq on request", 32'(irq_out), 1);
        ack_pair(v, vv);
        cmp("R6 vec_valid", 32'(vv), 1);
        cmp("R5 winner line3 vector", 32'(v), 32'h23);
        cmp("R5 isr set line3", 32'(isr_rd), 32'h08);
        cmp("R1 granted bit stays clear", 32'(irr_rd), 32'h20);
        cmp("R4 lower line blocked", 32'(irq_out), 0);
        req_line = 8'h2A; tick(2);
        cmp("R4 higher line nests", 32'(irq_out), 1);
        ack_pair(v, vv);
        cmp("R6 vec line1", 32'(v), 32'h21);
        cmp("R5 nested isr", 32'(isr_rd), 32'h0A);
        send_eoi(1'b0, 3'd0);
        cmp("R9 nonspecific clears line1", 32'(isr_rd), 32'h08);
        send_eoi(1'b1, 3'd3);
        cmp("R8 specific clears line3", 32'(isr_rd), 32'h00);
        cmp("R4 pending line5 raises irq", 32'(irq_out), 1);
        load_mask(8'h20); tick(1);
        cmp("R3 masked line5 irq low", 32'(irq_out), 0);
        cmp("R3 masked line5 visible", 32'(irr_rd), 32'h20);
        ack_pair(v, vv);
        cmp("R10 spurious vector", 32'(v), 32'h27);
        cmp("R10 isr unchanged", 32'(isr_rd), 32'h00);
        cmp("R10 irr unchanged", 32'(irr_rd), 32'h20);
        load_mask(8'h00);
        ack_pair(v, vv);
        cmp("R6 vec line5", 32'(v), 32'h25);
        send_eoi(1'b1, 3'd5);

        // auto EOI
        req_line = 8'h00; auto_eoi = 1'b1; tick(2);
        req_line = 8'h04; tick(2);
        ack_pair(v, vv);
        cmp("R7 auto eoi vector", 32'(v), 32'h22);
        cmp("R7 auto eoi clears isr", 32'(isr_rd), 32'h00);

        // level mode
        req_line = 8'h00; level_mode = 1'b1; tick(2);
        cmp("R2 level idle", 32'(irr_rd), 32'h00);
        req_line = 8'h10; tick(2);
        cmp("R2 level follows high", 32'(irr_rd), 32'h10);
        req_line = 8'h00; tick(2);
        cmp("R2 level drops", 32'(irr_rd), 32'h00);
        req_line = 8'h41; tick(2);
        ack_pair(v, vv);
        cmp("R5 line0 beats line6", 32'(v), 32'h20);
        req_line = 8'h40; vec_base = 8'hFC; tick(2);
        ack_pair(v, vv);
        cmp("R6 base wraps", 32'(v), 32'h02);
        req_line = 8'h00; auto_eoi = 1'b0; tick(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            compared++; mismatched++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule